// File: doc/BRIEF.md
# I2C Bit-Rate Tick Prescaler

This block derives the sampling tick of an I2C controller from a fast core clock. Three divide stages are chained. The first stage is a fixed prescale set by the parameter `THP`. The second divides by a power of two, 2^N. The third divides by M+1. The result is a one-cycle tick at ten times the intended SCL rate, so one SCL period spans ten ticks. The SCL waveform itself is produced elsewhere, from this tick.

Software writes a clock-control byte that carries the M and N values. The `mode_alt` input chooses how the first stage divides. In the standard mode it divides by 2×(THP+1). In the alternate mode it divides by THP+2. A written byte, and any change of `mode_alt`, waits until the current tick interval has finished. It then takes effect cleanly, so no tick comes early or late.

Top module: `i2c_rate_prescaler`

## Requirements
- R1: While `rst_n` is low, `tick` is low. Reset selects M=0, N=0 and the standard first stage. The first tick is high right after the P-th rising edge with `rst_n` high, where P is the period given in R4 for those settings.
- R2: In the standard mode the first stage divides the core clock by 2×(THP+1). With THP=3 and M=N=0, ticks are 8 cycles apart.
- R3: In the alternate mode the first stage divides by THP+2. With THP=3 and M=N=0, ticks are 5 cycles apart.
- R4: The interval between ticks is P = D1 × 2^N × (M+1) core cycles. D1 is the first-stage divisor. M is taken from bits 6:3 of the written byte and N from bits 2:0.
- R5: Bit 7 of the clock-control byte has no effect on the tick period.
- R6: A byte written with `cfg_we` high part-way through an interval does not change that interval. The new M and N govern every interval after the next tick.
- R7: `tick` is high for exactly one core cycle per interval.
- R8: `mode_alt` is sampled only at a tick boundary. A change part-way through an interval first affects the interval after the next tick.
- R9: The extreme settings M=15 and N=7 give the full period: 16384 cycles in the standard mode and 10240 cycles in the alternate mode when THP=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_alt | input | 1 | 1 selects the THP+2 first stage, 0 selects 2×(THP+1) |
| cfg_we | input | 1 | Write strobe for the clock-control byte |
| cfg_data | input | 8 | Clock-control byte: M in bits 6:3, N in bits 2:0, bit 7 unused |
| tick | output | 1 | One-cycle pulse at ten times the SCL rate |

## Verification
A wrong count or select in any stage shows at the port as a tick interval of the wrong length. It appears within one interval of the fault. A setting applied too early shortens or stretches the interval in which the write or mode change occurred, rather than the one after it. The bench therefore measures the interval in progress and the following interval for every change. Single-cycle width is checked on the cycle after each tick.

// File: rtl/i2c_rate_prescaler.sv
module i2c_rate_prescaler #(
  parameter int THP = 3,
  parameter int MW  = 4,
  parameter int NW  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_alt,
  input  logic       cfg_we,
  input  logic [7:0] cfg_data,
  output logic       tick
);
  localparam int D_STD = 2 * (THP + 1);
  localparam int D_ALT = THP + 2;
  localparam int CW    = $clog2(D_STD + 1);
  localparam int EW    = (1 << NW) - 1;

  logic [MW-1:0] pend_m, act_m, c3;
  logic [NW-1:0] pend_n, act_n;
  logic          act_alt;
  logic [CW-1:0] c1, d1_last;
  logic [EW-1:0] c2, e_last;
  logic          s1, s2, s3;

  assign d1_last = act_alt ? CW'(D_ALT - 1) : CW'(D_STD - 1);
  assign e_last  = (EW'(1) << act_n) - EW'(1);
  assign s1 = (c1 == d1_last);
  assign s2 = s1 && (c2 == e_last);
  assign s3 = s2 && (c3 == act_m);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_m  <= '0;
      pend_n  <= '0;
      act_m   <= '0;
      act_n   <= '0;
      act_alt <= 1'b0;
      c1      <= '0;
      c2      <= '0;
      c3      <= '0;
      tick    <= 1'b0;
    end else begin
      if (cfg_we) begin
        pend_m <= cfg_data[NW+MW-1:NW];
        pend_n <= cfg_data[NW-1:0];
      end
      c1 <= s1 ? '0 : c1 + CW'(1);
      if (s1) c2 <= s2 ? '0 : c2 + EW'(1);
      if (s2) c3 <= s3 ? '0 : c3 + MW'(1);
      tick <= s3;
      if (s3) begin
        act_m   <= pend_m;
        act_n   <= pend_n;
        act_alt <= mode_alt;
      end
    end
  end

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_cfg_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_m) || !$stable(act_n) || !$stable(act_alt)) |-> tick);

  assert_stage1_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c1 <= d1_last);

  assert_stage3_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c3 <= act_m);

  assert_tick_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (c1 == '0 && c2 == '0 && c3 == '0));
endmodule

// File: tb/sim_i2c_rate_prescaler.sv
module sim_i2c_rate_prescaler;
  localparam int THP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_alt = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       tick;

  int tests = 0;
  int fails = 0;
  int prev_p;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_rate_prescaler #(.THP(THP)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_alt(mode_alt),
    .cfg_we(cfg_we), .cfg_data(cfg_data), .tick(tick)
  );

  function automatic int period(input bit alt, input int m, input int n);
    int d1;
    d1 = alt ? (THP + 2) : (2 * (THP + 1));
    return d1 * (1 << n) * (m + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      cfg_we = 1'b0;
      n++;
      if (n == 1 && tick) begin
        tests++;
        fails++;
        $display("FAIL R7: actual tick 1 expected 0 on cycle after tick");
      end
    end while (!tick && n < 20000);
  endtask

  task automatic apply(input string req, input logic [7:0] b, input bit alt);
    int n;
    int p;
    p = period(alt, int'(b[6:3]), int'(b[2:0]));
    cfg_we = 1'b1;
    cfg_data = b;
    mode_alt = alt;
    next_tick(n);
    check("R6/R8 old interval", n, prev_p);
    next_tick(n);
    check(req, n, p);
    prev_p = p;
  endtask

  initial begin
    #3000000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 tick low in reset", int'(tick), 0);
    rst_n = 1'b1;
    next_tick(n);
    check("R1 first tick latency", n, period(0, 0, 0));
    next_tick(n);
    check("R2 standard first stage", n, 8);
    prev_p = 8;

    apply("R4 M=2 N=1", 8'b0_0010_001, 1'b0);
    apply("R5 bit7 ignored", 8'b1_0001_000, 1'b0);
    apply("R3 alternate first stage", 8'h00, 1'b1);
    check("R3 literal", prev_p, 5);
    apply("R8 mode back", 8'b0_0011_010, 1'b0);
    apply("R9 extreme standard", 8'b0_1111_111, 1'b0);
    check("R9 literal std", prev_p, 16384);
    apply("R9 extreme alternate", 8'b0_1111_111, 1'b1);
    check("R9 literal alt", prev_p, 10240);
    apply("R5 bit7 with alt", 8'b1_0000_000, 1'b1);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      bit alt;
      b[7]   = 1'($urandom);
      b[6:3] = 4'($urandom);
      b[2:0] = 3'($urandom % 5);
      alt    = 1'($urandom);
      apply("R4 random", b, alt);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule